// File: doc/BRIEF.md
# Status Register Write Protection Unit

This unit keeps the protection state of a serial memory: a write-enable latch, a two-bit block-protect field that selects a protected top region of the array, and a protect-enable bit. Together with an external active-low lock pin, these bits decide two things. One is whether the status register may be rewritten. The other is whether the memory word at a given address may be written. The serial engine reports each opcode it decodes and each status byte it receives. It also presents the current memory address. In return it gets a memory-write grant and a status-write grant, which it must obey.

Commands that change the write-enable latch take effect when chip select returns high. The lock pin is sampled on every clock while chip select is high and is frozen while it is low. A lock pin that falls during a transfer therefore cannot cancel a status write that is already under way. A status readback byte is also assembled here, with an active-low ready flag driven from the store-busy input. Nonvolatile storage and the bit shifting itself belong to other blocks.

Top module: `sr_guard`

## Requirements
- R1: After reset the write-enable latch, the protect-enable bit and both block-protect bits are 0, and no grant is given.
- R2: While the write-enable latch is 0, `mem_wr_grant` and `sr_wr_grant` are both 0, and a status byte offered on `sr_wr_valid` changes nothing.
- R3: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it. Either change appears on the clock edge where `cs_n` is first seen high again, and not earlier.
- R4: When the write-enable latch is 1 and the protect-enable bit is 0, `sr_wr_grant` is 1 whatever the lock pin level. A granted byte loads bit 7 into the protect-enable bit and bits 3:2 into the block-protect field. Its other bits are ignored.
- R5: When the write-enable latch is 1, the protect-enable bit is 1 and the captured lock level is low, `sr_wr_grant` is 0 and a status byte leaves the register unchanged. Writes to unprotected memory are still granted.
- R6: The block-protect field selects the protected region: 00 protects nothing, 01 protects the top quarter of the address space, 10 the top half and 11 all of it. A protected address never receives `mem_wr_grant`.
- R7: A transaction whose opcode is 0x02 (memory write) or 0x01 (status write) clears the write-enable latch when `cs_n` rises.
- R8: The lock level is taken on the last clock edge before `cs_n` goes low and held until `cs_n` returns high. A change of the pin during the transfer does not change `sr_wr_grant`.
- R9: `sr_rdata` shows the protect-enable bit at bit 7, the block-protect field at bits 3:2, the write-enable latch at bit 1, and `busy` at bit 0 (1 = not ready). Bits 6:4 read 0.
- R10: Only the first opcode of a transaction acts. An opcode other than 0x01, 0x02, 0x04 or 0x06 has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low; a low period is one transaction |
| lock_n | input | 1 | External lock pin, low means lock the status register |
| busy | input | 1 | Store cycle in progress; shown as the not-ready flag |
| cmd_valid | input | 1 | One-cycle strobe: `cmd_code` holds a decoded opcode |
| cmd_code | input | 8 | Opcode byte |
| sr_wr_valid | input | 1 | One-cycle strobe: `sr_wr_data` holds a status byte |
| sr_wr_data | input | 8 | Status byte offered for writing |
| mem_addr | input | ADDR_W | Memory address to be judged |
| mem_wr_grant | output | 1 | Write to `mem_addr` allowed |
| sr_wr_grant | output | 1 | Status register write allowed |
| sr_rdata | output | 8 | Status readback byte |

## Verification
The bench builds the unit with the default 17-bit address. At this width the quarter and half boundaries of the protected region fall at 0x18000 and 0x10000. A table probes the last unprotected and the first protected word at each boundary, plus both ends of the array, for every block-protect code. Directed sequences then check how the captured lock level interacts with the protect-enable bit, including a pin drop in the middle of a status write. They also check that latch changes wait for the rise of chip select, and that only the first opcode of a transaction counts.

// File: rtl/sr_guard_pkg.sv
package sr_guard_pkg;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_SET,
        OP_CLR,
        OP_WSEQ,
        OP_IGN
    } op_e;

    localparam logic [7:0] OPC_WRSR  = 8'h01;
    localparam logic [7:0] OPC_WRITE = 8'h02;
    localparam logic [7:0] OPC_WRDI  = 8'h04;
    localparam logic [7:0] OPC_WREN  = 8'h06;

    localparam int BIT_PEN  = 7;
    localparam int BIT_BPHI = 3;
    localparam int BIT_BPLO = 2;
    localparam int BIT_WEN  = 1;
    localparam int BIT_RDYN = 0;

    localparam logic [7:0] CTL_MASK = 8'h8C;

endpackage

// File: rtl/sr_guard_region.sv
module sr_guard_region #(
    parameter int ADDR_W = 17
) (
    input  logic [1:0]        bp,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    localparam logic [ADDR_W-1:0] QTR_BASE  = ADDR_W'(3) << (ADDR_W - 2);
    localparam logic [ADDR_W-1:0] HALF_BASE = ADDR_W'(1) << (ADDR_W - 1);

    always_comb begin
        unique case (bp)
            2'b00:   hit = 1'b0;
            2'b01:   hit = (addr >= QTR_BASE);
            2'b10:   hit = (addr >= HALF_BASE);
            default: hit = 1'b1;
        endcase
    end
endmodule

// File: rtl/sr_guard_txn.sv
module sr_guard_txn
    import sr_guard_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       lock_n,
    input  logic       cmd_valid,
    input  logic [7:0] cmd_code,
    output logic       lock_cap,
    output logic       cs_rise,
    output op_e        op
);
    typedef struct packed {
        logic cs;
        logic lock;
        op_e  op;
    } txn_t;

    txn_t st_d, st_q;

    function automatic op_e decode(input logic [7:0] c);
        case (c)
            OPC_WREN:            return OP_SET;
            OPC_WRDI:            return OP_CLR;
            OPC_WRITE, OPC_WRSR: return OP_WSEQ;
            default:             return OP_IGN;
        endcase
    endfunction

    always_comb begin
        st_d    = st_q;
        st_d.cs = cs_n;
        if (cs_n) begin
            st_d.lock = lock_n;
            st_d.op   = OP_NONE;
        end else if (cmd_valid && st_q.op == OP_NONE) begin
            st_d.op = decode(cmd_code);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cs   <= 1'b1;
            st_q.lock <= 1'b0;
            st_q.op   <= OP_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign lock_cap = st_q.lock;
    assign cs_rise  = cs_n & ~st_q.cs;
    assign op       = st_q.op;

    // R8: captured lock level frozen while select stays low
    assert_lock_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !$past(cs_n)) |-> $stable(st_q.lock));

    // R10: an opcode already held is not replaced within the transaction
    assert_first_op_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && st_q.op != OP_NONE) |=> $stable(st_q.op));
endmodule

// File: rtl/sr_guard.sv
module sr_guard
    import sr_guard_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              lock_n,
    input  logic              busy,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_code,
    input  logic              sr_wr_valid,
    input  logic [7:0]        sr_wr_data,
    input  logic [ADDR_W-1:0] mem_addr,
    output logic              mem_wr_grant,
    output logic              sr_wr_grant,
    output logic [7:0]        sr_rdata
);
    typedef struct packed {
        logic       wen;
        logic [7:0] ctl;
    } reg_t;

    reg_t r_d, r_q;
    logic lock_cap, cs_rise, region_hit;
    op_e  op;

    sr_guard_txn u_txn (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .lock_n    (lock_n),
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .lock_cap  (lock_cap),
        .cs_rise   (cs_rise),
        .op        (op)
    );

    sr_guard_region #(.ADDR_W(ADDR_W)) u_region (
        .bp   (r_q.ctl[BIT_BPHI:BIT_BPLO]),
        .addr (mem_addr),
        .hit  (region_hit)
    );

    assign sr_wr_grant  = r_q.wen & (~r_q.ctl[BIT_PEN] | lock_cap);
    assign mem_wr_grant = r_q.wen & ~region_hit;

    always_comb begin
        r_d = r_q;
        if (!cs_n && sr_wr_valid && sr_wr_grant)
            r_d.ctl = sr_wr_data & CTL_MASK;
        if (cs_rise) begin
            case (op)
                OP_SET:          r_d.wen = 1'b1;
                OP_CLR, OP_WSEQ: r_d.wen = 1'b0;
                default:         r_d.wen = r_q.wen;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.wen <= 1'b0;
            r_q.ctl <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        sr_rdata           = r_q.ctl;
        sr_rdata[BIT_WEN]  = r_q.wen;
        sr_rdata[BIT_RDYN] = busy;
    end

    // R2: no grant of any kind without the write-enable latch
    assert_no_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !sr_rdata[BIT_WEN] |-> (!mem_wr_grant && !sr_wr_grant));

    // R6: a protected address is never granted
    assert_region_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        region_hit |-> !mem_wr_grant);

    // R5: a refused status byte leaves the register bits untouched
    assert_denied_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_wr_valid && !sr_wr_grant) |=> $stable(sr_rdata[7:2]));

    // R7: a write sequence ends with the latch cleared
    assert_wen_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && op == OP_WSEQ) |=> !sr_rdata[BIT_WEN]);

    // R3: the latch only moves on the rise of select
    assert_wen_on_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_rise |=> $stable(sr_rdata[BIT_WEN]));
endmodule

// File: tb/sr_guard_tb_top.sv
module sr_guard_tb_top;
    localparam int AW = 17;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1;
    logic          lock_n = 1'b1;
    logic          busy = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [7:0]    cmd_code = '0;
    logic          sr_wr_valid = 1'b0;
    logic [7:0]    sr_wr_data = '0;
    logic [AW-1:0] mem_addr = '0;
    logic          mem_wr_grant, sr_wr_grant;
    logic [7:0]    sr_rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    sr_guard #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .lock_n(lock_n), .busy(busy),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .sr_wr_valid(sr_wr_valid), .sr_wr_data(sr_wr_data),
        .mem_addr(mem_addr), .mem_wr_grant(mem_wr_grant),
        .sr_wr_grant(sr_wr_grant), .sr_rdata(sr_rdata)
    );

    // {block-protect code, address}
    localparam logic [AW+1:0] PROBES [12] = '{
        {2'b00, 17'h00000}, {2'b00, 17'h1FFFF},
        {2'b01, 17'h17FFF}, {2'b01, 17'h18000},
        {2'b01, 17'h1FFFF}, {2'b01, 17'h00000},
        {2'b10, 17'h0FFFF}, {2'b10, 17'h10000},
        {2'b10, 17'h1FFFF}, {2'b11, 17'h00000},
        {2'b11, 17'h0FFFF}, {2'b11, 17'h1FFFF}
    };

    function automatic logic allowed(input logic [1:0] bp, input logic [AW-1:0] a);
        case (bp)
            2'b00:   return 1'b1;
            2'b01:   return a < 17'h18000;
            2'b10:   return a < 17'h10000;
            default: return 1'b0;
        endcase
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic txn(input logic [7:0] opc);
        @(negedge clk) cs_n = 1'b0;
        @(negedge clk) begin cmd_valid = 1'b1; cmd_code = opc; end
        @(negedge clk) cmd_valid = 1'b0;
        @(negedge clk) cs_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wrsr(input logic [7:0] data);
        @(negedge clk) cs_n = 1'b0;
        @(negedge clk) begin cmd_valid = 1'b1; cmd_code = 8'h01; end
        @(negedge clk) begin cmd_valid = 1'b0; sr_wr_valid = 1'b1; sr_wr_data = data; end
        @(negedge clk) sr_wr_valid = 1'b0;
        @(negedge clk) cs_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 rdata", sr_rdata, 8'h00);
        chk("R1 grants", {6'b0, mem_wr_grant, sr_wr_grant}, 8'h00);

        // R9 ready flag follows busy
        busy = 1'b1;
        @(negedge clk) chk("R9 busy", sr_rdata, 8'h01);
        busy = 1'b0;

        // R2 status byte ignored while latch clear
        wrsr(8'h8C);
        chk("R2 ignored", sr_rdata, 8'h00);
        chk("R2 mem grant", {7'b0, mem_wr_grant}, 8'h00);

        // R3 latch waits for rise of select
        @(negedge clk) cs_n = 1'b0;
        @(negedge clk) begin cmd_valid = 1'b1; cmd_code = 8'h06; end
        @(negedge clk) cmd_valid = 1'b0;
        @(negedge clk) chk("R3 not yet", sr_rdata, 8'h00);
        cs_n = 1'b1;
        @(negedge clk) chk("R3 set", sr_rdata, 8'h02);

        // R4 / R7 granted status write, masked bits, latch cleared
        lock_n = 1'b0;
        @(negedge clk) chk("R4 grant pen0", {7'b0, sr_wr_grant}, 8'h01);
        wrsr(8'hFF);
        chk("R4 R7 rdata", sr_rdata, 8'h8C);
        lock_n = 1'b1;

        // R6 region table walk
        for (int i = 0; i < 12; i++) begin
            txn(8'h06);
            wrsr({6'b0, PROBES[i][AW+1:AW]} << 2);
            txn(8'h06);
            mem_addr = PROBES[i][AW-1:0];
            @(negedge clk)
            chk($sformatf("R6 probe %0d", i), {7'b0, mem_wr_grant},
                {7'b0, allowed(PROBES[i][AW+1:AW], PROBES[i][AW-1:0])});
        end

        // R5 lock low with protect-enable set
        wrsr(8'h80);
        txn(8'h06);
        lock_n = 1'b0;
        @(negedge clk) cs_n = 1'b0;
        @(negedge clk) begin cmd_valid = 1'b1; cmd_code = 8'h01; end
        @(negedge clk) begin
            cmd_valid = 1'b0;
            chk("R5 sr grant", {7'b0, sr_wr_grant}, 8'h00);
            sr_wr_valid = 1'b1; sr_wr_data = 8'h0C;
        end
        @(negedge clk) sr_wr_valid = 1'b0;
        @(negedge clk) cs_n = 1'b1;
        @(negedge clk) chk("R5 unchanged", sr_rdata, 8'h80);
        txn(8'h06);
        mem_addr = 17'h1FFFF;
        @(negedge clk) chk("R5 mem grant", {7'b0, mem_wr_grant}, 8'h01);

        // R8 lock drops mid-transfer, write still lands
        lock_n = 1'b1;
        @(negedge clk) cs_n = 1'b0;
        @(negedge clk) begin cmd_valid = 1'b1; cmd_code = 8'h01; lock_n = 1'b0; end
        @(negedge clk) begin
            cmd_valid = 1'b0;
            chk("R8 grant held", {7'b0, sr_wr_grant}, 8'h01);
            sr_wr_valid = 1'b1; sr_wr_data = 8'h04;
        end
        @(negedge clk) sr_wr_valid = 1'b0;
        @(negedge clk) cs_n = 1'b1;
        @(negedge clk) chk("R8 applied", sr_rdata, 8'h04);

        // R10 first opcode wins, unknown opcode inert
        @(negedge clk) cs_n = 1'b0;
        @(negedge clk) begin cmd_valid = 1'b1; cmd_code = 8'h06; end
        @(negedge clk) cmd_code = 8'h04;
        @(negedge clk) cmd_valid = 1'b0;
        @(negedge clk) cs_n = 1'b1;
        @(negedge clk) chk("R10 first wins", sr_rdata, 8'h06);
        txn(8'h9A);
        chk("R10 unknown", sr_rdata, 8'h06);

        // R3 clear command
        txn(8'h04);
        chk("R3 clear", sr_rdata, 8'h04);

        // R7 memory write sequence clears latch
        txn(8'h06);
        txn(8'h02);
        chk("R7 write seq", sr_rdata, 8'h04);

        finish_run();
    end
endmodule